// File: doc/BRIEF.md
# Phase Accumulator Sine Oscillator

This block is a numerically controlled oscillator. A wide phase register advances by a programmable tuning word on every enabled clock. Only the top bits of that phase address the sine lookup. The lookup stores a single quadrant of the wave. The two most significant truncated phase bits pick the quadrant: they decide whether the quadrant address is mirrored and whether the magnitude is negated. The result is a signed amplitude word that covers the full cycle.

The block is meant to feed a converter or a downstream digital path. Software or a neighbouring block supplies the tuning word. The output frequency is tune × f_clk / 2^ACC_W, so the finest frequency step is f_clk / 2^ACC_W. Truncating the phase makes the table smaller but does not coarsen that step. A new tuning word takes effect on the next addition. The phase is not cleared, so the waveform stays continuous.

Top module: `phase_nco`

## Requirements
- R1: While rst_ni is low, and immediately after reset, the phase is zero, valid_o is 0 and amp_o is 0.
- R2: On each rising clock edge with en_i high, the phase becomes (phase + tune_i) mod 2^ACC_W.
- R3: On an edge with en_i low, the phase holds. No new sample enters the pipeline. When valid_o is low, amp_o keeps its previous value.
- R4: Only the top PH_W phase bits (default 13) select the amplitude. Phases that differ only in the lower ACC_W−PH_W bits give the same amplitude.
- R5: Quarter-table entry k, for k = 0..2^(PH_W−2)−1, equals int'(F·sin(π/2 · k/(2^(PH_W−2)−1))) with F = 2^(AMP_W−1)−1 (32767 by default). amp_o never takes the value −2^(AMP_W−1).
- R6: The truncated phase splits into q = its top two bits and r = the remaining PH_W−2 bits. When q[0] = 1 the table address is ~r, otherwise it is r. When q[1] = 1 the amplitude is the negated entry.
- R7: The phase present when en_i is sampled high at edge E appears as a two's-complement amplitude on amp_o after edge E+1. valid_o is high for exactly that one cycle. So valid_o equals en_i delayed by two edges.
- R8: A change of tune_i takes effect on the next enabled edge, starting from the current phase, with no reset of the phase.
- R9: With tune_i = 2^(ACC_W−2) from reset, the output samples repeat every four clocks: 0, +F, 0, −F.
- R10: The phase wraps modulo 2^ACC_W. Tuning words with the top bit set act as negative steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Advance phase and launch one sample |
| tune_i | input | ACC_W | Phase increment per enabled clock |
| amp_o | output | AMP_W | Signed amplitude sample |
| valid_o | output | 1 | amp_o holds a new sample this cycle |

## Verification
The bench targets the quadrant seams, where the four-clock quarter-rate pattern must read exactly 0, +F, 0, −F. A wrong mirror or sign would instead give a repeated peak, a zero where the peak belongs, or a positive half-wave where a negative one belongs. A tiny tuning word checks that the lower phase bits stay out of the address; a design that tapped the wrong bits would produce non-zero samples. Tests with negative and near-half-range tuning words exercise wraparound and odd-quadrant mirroring at off-axis addresses. An enable gap followed by a tuning change checks phase continuity and that valid_o tracks the two-stage pipeline; an off-by-one latency would line up with the wrong phase.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    QUAD_RISE  = 2'd0,
    QUAD_FALL  = 2'd1,
    QUAD_NRISE = 2'd2,
    QUAD_NFALL = 2'd3
  } quad_e;

  localparam real HALF_PI = 1.5707963267948966;

  // odd quadrants walk the table backwards
  function automatic logic quad_mirror(quad_e q);
    return (q == QUAD_FALL) || (q == QUAD_NFALL);
  endfunction

  // lower half-cycle is negative
  function automatic logic quad_negate(quad_e q);
    return (q == QUAD_NRISE) || (q == QUAD_NFALL);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tune_i,
  output logic [ACC_W-1:0] phase_o
);

  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (en_i) begin
      phase_q <= phase_q + tune_i;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/nco_quad_map.sv
module nco_quad_map
  import nco_pkg::*;
#(
  parameter int PH_W = 13,
  localparam int ADDR_W = PH_W - 2
) (
  input  logic [PH_W-1:0]   trunc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              neg_o
);

  quad_e             quad_w;
  logic [ADDR_W-1:0] rest_w;

  assign quad_w = quad_e'(trunc_i[PH_W-1 -: 2]);
  assign rest_w = trunc_i[ADDR_W-1:0];

  always_comb begin
    addr_o = quad_mirror(quad_w) ? ~rest_w : rest_w;
    neg_o  = quad_negate(quad_w);
  end

endmodule

// File: rtl/nco_sine_rom.sv
module nco_sine_rom
  import nco_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int MAG_W  = 15,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int FULL  = (1 << MAG_W) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MAG_W-1:0]  mag_o
);

  function automatic logic [MAG_W-1:0] entry(int k);
    real v;
    v = real'(FULL) * $sin(HALF_PI * real'(k) / real'(DEPTH - 1));
    return MAG_W'(int'(v));
  endfunction

  logic [MAG_W-1:0] rom_w [DEPTH];
  logic [MAG_W-1:0] mag_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    localparam logic [MAG_W-1:0] VAL = entry(k);
    assign rom_w[k] = VAL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
    end else if (ld_i) begin
      mag_q <= rom_w[addr_i];
    end
  end

  assign mag_o = mag_q;

endmodule

// File: rtl/nco_sign_stage.sv
module nco_sign_stage #(
  parameter int AMP_W = 16,
  localparam int MAG_W = AMP_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             neg_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [AMP_W-1:0] amp_o,
  output logic             valid_o
);

  logic [AMP_W-1:0] amp_q;
  logic [AMP_W-1:0] pos_w;
  logic             valid_q;

  assign pos_w = {1'b0, mag_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= ld_i;
      if (ld_i) amp_q <= neg_i ? (~pos_w + 1'b1) : pos_w;
    end
  end

  assign amp_o   = amp_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/phase_nco.sv
module phase_nco #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 13,
  parameter int AMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tune_i,
  output logic [AMP_W-1:0] amp_o,
  output logic             valid_o
);

  localparam int ADDR_W = PH_W - 2;
  localparam int MAG_W  = AMP_W - 1;

  logic [ACC_W-1:0]  phase_w;
  logic [ADDR_W-1:0] addr_w;
  logic              neg_w;
  logic [MAG_W-1:0]  mag_w;
  logic              neg_q;
  logic              v1_q;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tune_i (tune_i),
    .phase_o(phase_w)
  );

  nco_quad_map #(.PH_W(PH_W)) u_map (
    .trunc_i(phase_w[ACC_W-1 -: PH_W]),
    .addr_o (addr_w),
    .neg_o  (neg_w)
  );

  nco_sine_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (en_i),
    .addr_i(addr_w),
    .mag_o (mag_w)
  );

  // sign travels alongside the table read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      neg_q <= 1'b0;
      v1_q  <= 1'b0;
    end else begin
      v1_q <= en_i;
      if (en_i) neg_q <= neg_w;
    end
  end

  nco_sign_stage #(.AMP_W(AMP_W)) u_sign (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (v1_q),
    .neg_i  (neg_q),
    .mag_i  (mag_w),
    .amp_o  (amp_o),
    .valid_o(valid_o)
  );

endmodule

// File: rtl/nco_checks.sv
module nco_checks #(
  parameter int ACC_W = 32,
  parameter int AMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [ACC_W-1:0] tune_i,
  input logic [ACC_W-1:0] phase_i,
  input logic [AMP_W-1:0] amp_i,
  input logic             valid_i
);

  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && $past(en_i)) |-> phase_i == ACC_W'($past(phase_i) + $past(tune_i))); // R2

  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !$past(en_i)) |-> phase_i == $past(phase_i)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && !valid_i) |-> amp_i == $past(amp_i)); // R3

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> valid_i == $past(en_i, 2)); // R7

  AST_NO_MIN_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_i != {1'b1, {(AMP_W-1){1'b0}}}); // R5

endmodule

bind phase_nco nco_checks #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_i   (en_i),
  .tune_i (tune_i),
  .phase_i(phase_w),
  .amp_i  (amp_o),
  .valid_i(valid_o)
);

// File: tb/test_phase_nco.sv
`timescale 1ns/1ps
module test_phase_nco;

  localparam int  ACC_W = 32;
  localparam int  PH_W  = 13;
  localparam int  AMP_W = 16;
  localparam int  FULL  = 32767;
  localparam real HPI   = 1.5707963267948966;
  localparam int  NSEG  = 8;

  localparam logic [31:0] SEG_TUNE [NSEG] = '{
    32'h0000_0001, 32'h0123_4567, 32'h0123_4567, 32'h1000_0000,
    32'hF000_0000, 32'h7FFF_FFFF, 32'h4008_0000, 32'h0000_8000};
  localparam int    SEG_LEN [NSEG] = '{12, 40, 6, 20, 20, 16, 12, 30};
  localparam bit    SEG_EN  [NSEG] = '{1, 1, 0, 1, 1, 1, 1, 1};
  localparam string SEG_TAG [NSEG] = '{"R4", "R2", "R3", "R8", "R10", "R6", "R6", "R5"};

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [ACC_W-1:0] tune_i = '0;
  logic [AMP_W-1:0] amp_o;
  logic             valid_o;

  int checks = 0;
  int errors = 0;

  // cycle model built from the requirements
  logic [31:0] m_phase;
  int          m_s1, m_amp;
  logic        m_v1, m_valid;

  always #2 clk = ~clk;

  phase_nco #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W)) i_phase_nco (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tune_i(tune_i),
    .amp_o(amp_o), .valid_o(valid_o));

  function automatic int expect_amp(logic [31:0] ph);
    logic [12:0] t;
    logic [10:0] a;
    int m;
    t = ph[31:19];
    a = t[11] ? ~t[10:0] : t[10:0];
    m = int'(real'(FULL) * $sin(HPI * real'(int'(a)) / real'(2047)));
    return t[12] ? -m : m;
  endfunction

  task automatic chk(input string tag, input int act, input int exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
    end
  endtask

  task automatic model_reset();
    m_phase = '0; m_s1 = 0; m_amp = 0; m_v1 = 1'b0; m_valid = 1'b0;
  endtask

  task automatic step(input logic en, input logic [31:0] tw);
    en_i = en; tune_i = tw;
    @(posedge clk);
    m_valid = m_v1;
    if (m_v1) m_amp = m_s1;
    if (en) m_s1 = expect_amp(m_phase);
    m_v1 = en;
    if (en) m_phase = m_phase + tw;
    @(negedge clk);
  endtask

  task automatic cmp(input string tag);
    chk(tag, int'($signed(amp_o)), m_amp);
    chk(tag, int'(valid_o), int'(m_valid));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; en_i = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1", int'($signed(amp_o)), 0);
    chk("R1", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", int'($signed(amp_o)), 0);
    chk("R1", int'(valid_o), 0);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seq [6];
    model_reset();
    repeat (3) @(negedge clk);
    do_reset();

    // vector table walk
    for (int s = 0; s < NSEG; s++) begin
      for (int c = 0; c < SEG_LEN[s]; c++) begin
        step(SEG_EN[s], SEG_TUNE[s]);
        cmp(SEG_TAG[s]);
      end
    end

    // R9: quarter-rate pattern from reset
    do_reset();
    for (int c = 0; c < 6; c++) begin
      step(1'b1, 32'h4000_0000);
      cmp("R9");
      seq[c] = int'($signed(amp_o));
    end
    chk("R9", seq[1], 0);
    chk("R9", seq[2], FULL);
    chk("R9", seq[3], 0);
    chk("R9", seq[4], -FULL);
    chk("R9", seq[5], 0);

    // R7: single enable pulse -> one valid, two edges later
    do_reset();
    step(1'b1, 32'h4000_0000);
    chk("R7", int'(valid_o), 0);
    step(1'b0, 32'h0);
    chk("R7", int'(valid_o), 1);
    chk("R7", int'($signed(amp_o)), 0);
    step(1'b0, 32'h0);
    chk("R7", int'(valid_o), 0);
    chk("R3", int'($signed(amp_o)), 0);
    step(1'b1, 32'h0);
    step(1'b0, 32'h0);
    chk("R7", int'($signed(amp_o)), FULL);

    // R1: reset mid-run clears phase
    step(1'b1, 32'h1234_5678);
    step(1'b1, 32'h1234_5678);
    do_reset();
    step(1'b1, 32'h4000_0000);
    step(1'b0, 32'h0);
    chk("R1", int'($signed(amp_o)), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule